// File: doc/BRIEF.md
# Synchronous Serial Port Master with Frame FIFOs

This block is a serial peripheral interface master for a processor bus. Software sets the frame width, the clock polarity and phase, and a two-stage clock divider through a small register file. It then writes frames into an eight-entry transmit queue. The block shifts each frame out most significant bit first. For every frame sent it captures one frame from the serial input and places it in an eight-entry receive queue, which software drains through the same data register.

Three interrupt sources are kept in one identify register, and each has its own enable: transmit queue running low, receive queue filling up, and receive overrun. They are combined onto a single request line. Chip selects are driven outside the block. A loopback switch routes the serial output back into the receiver, which allows a self test without a connected device.

Top module: `ssp_master`

## Requirements
- R1: After reset the control registers at offsets 0x00 and 0x04 read 0, the prescale register at 0x10 reads 2, the status register at 0x0C reads 0x0003, the identify register at 0x14 reads 0, `irq` is low and `spi_sclk` is low.
- R2: Offset 0x00 bits [3:0] hold the frame width minus one, for widths of 4 to 16 bits. Frames are sent most significant bit first, and data bits above the width are not transmitted. Received frames are right-aligned and zero-extended.
- R3: Each half period of `spi_sclk` lasts (P/2)×(S+1) clock cycles. P is the prescale value at 0x10 bits [7:1] with bit 0 forced to 0. S is offset 0x00 bits [15:8].
- R4: Offset 0x00 bit 7 selects the polarity and bit 6 selects the phase. The clock rests at the polarity level between transfers and leaves it on the first edge of a frame. With phase 0, data is sampled on leading edges and the first bit is valid before the first edge. With phase 1, data changes on leading edges and is sampled on trailing edges.
- R5: Every transmitted frame captures exactly one received frame. The transmitted and received frames keep their order.
- R6: Writing offset 0x08 queues a frame in an 8-deep transmit queue. A write while that queue is full is ignored.
- R7: Reading offset 0x08 returns the oldest received frame and removes it. A read while the receive queue is empty returns 0 and changes nothing.
- R8: The status register at 0x0C reports: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, and bit 4 busy (a frame is in progress or the transmit queue holds data).
- R9: A frame that completes while the receive queue is full is dropped and sets a sticky overrun flag. Any write to offset 0x14 clears the flag.
- R10: Offset 0x14 reads the following sources, each gated by its enable in offset 0x04:
  - bit 0: receive queue holds at least 4 frames (enable bit 0);
  - bit 1: transmit queue holds at most 4 frames (enable bit 1);
  - bit 2: overrun (enable bit 2).
  `irq` is high when any of these bits is set.
- R11: Offset 0x04 bit 3 feeds the serial output back into the receiver and ignores `spi_miso`.
- R12: Offset 0x04 bit 4 enables the port. Clearing it abandons any frame in progress without queuing a partial receive frame. `spi_sclk` then returns to the polarity level, and busy clears once the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (removes a frame when it reads the data offset) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, valid in the same cycle |
| irq | output | 1 | Combined interrupt request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A device model in the bench follows `spi_sclk` on every clock. It rebuilds each outgoing frame from the edges that the chosen phase defines, drives its own reply bits, and times every half period within a frame. The runs cover all four polarity and phase combinations, widths of 4, 5, 8, 12 and 16 bits, and several divider settings, including an odd prescale value. These runs separate wrong edge choice, wrong bit order and wrong divider arithmetic. Queue-full, overrun and loopback runs show whether frames are dropped or kept and whether the reply comes from the pin or from the transmitter. A disable issued in the middle of a frame checks that the clock returns to its rest level and that no stray frame is received.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int FRAME_MAX = 16;
    localparam int ADDR_W    = 5;

    localparam logic [ADDR_W-1:0] OFS_CTRL_FMT  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL_PORT = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA      = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STATUS    = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_PRESCALE  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_INT       = 5'h14;

    // frame format register layout
    typedef struct packed {
        logic [7:0] rate;
        logic       cpol;
        logic       cpha;
        logic [1:0] spare;
        logic [3:0] size_code;
    } fmt_reg_t;

    // port control register layout, bit 0 at the bottom
    typedef struct packed {
        logic en;
        logic loop;
        logic ovr_ie;
        logic tx_ie;
        logic rx_ie;
    } port_reg_t;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic [3:0] last_bit;
    } link_cfg_t;

    // size codes below 3 behave as a 4-bit frame
    function automatic logic [3:0] fix_size(input logic [3:0] code);
        return (code < 4'd3) ? 4'd3 : code;
    endfunction

    function automatic logic [FRAME_MAX-1:0] size_mask(input logic [3:0] last_bit);
        return {FRAME_MAX{1'b1}} >> (4'd15 - last_bit);
    endfunction

    // prescale counter limit: half the even prescale, minus one; below 2 acts as 2
    function automatic logic [6:0] half_prescale(input logic [7:0] pre);
        return (pre[7:1] == 7'd0) ? 7'd0 : pre[7:1] - 7'd1;
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = mem[rd_ptr];
    assign count   = cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    assert_full_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (cnt == CW'(DEPTH)));

    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [7:0] prescale,
    input  logic [7:0] rate,
    output logic       tick
);
    import ssp_pkg::*;

    logic [6:0] pre_lim;
    logic [6:0] pre_cnt;
    logic [7:0] div_cnt;
    logic       pre_wrap, div_wrap;

    assign pre_lim  = half_prescale(prescale);
    assign pre_wrap = (pre_cnt >= pre_lim);
    assign div_wrap = (div_cnt >= rate);
    assign tick     = run && pre_wrap && div_wrap;

    // first stage: prescale/2 cycles; second stage: rate+1 of those
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int W = ssp_pkg::FRAME_MAX
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                loop,
    input  ssp_pkg::link_cfg_t  cfg,
    input  logic                tick,
    input  logic                tx_valid,
    input  logic [W-1:0]        tx_word,
    output logic                tx_take,
    output logic                rx_put,
    output logic [W-1:0]        rx_word,
    output logic                active,
    output logic                sclk_o,
    output logic                mosi_o,
    input  logic                miso_i
);
    import ssp_pkg::*;

    localparam int EW = $clog2(2 * W);

    logic [EW-1:0] edge_cnt;
    logic [EW-1:0] edge_last;
    logic [W-1:0]  tx_sr, rx_sr, rx_next;
    logic          drive_e, samp_e, ser_in;
    logic          start, done, reload;

    assign edge_last = {cfg.last_bit, 1'b1};
    assign samp_e    = cfg.cpha ? edge_cnt[0] : !edge_cnt[0];
    assign drive_e   = cfg.cpha ? !edge_cnt[0] : (edge_cnt[0] && (edge_cnt != edge_last));
    assign ser_in    = loop ? mosi_o : miso_i;
    assign rx_next   = samp_e ? {rx_sr[W-2:0], ser_in} : rx_sr;

    assign start   = en && !active && tx_valid;
    assign done    = en && active && tick && (edge_cnt == edge_last);
    assign reload  = done && tx_valid;
    assign tx_take = start || reload;
    assign rx_put  = done;
    assign rx_word = rx_next & size_mask(cfg.last_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            edge_cnt <= '0;
            sclk_o   <= 1'b0;
            mosi_o   <= 1'b0;
            tx_sr    <= '0;
            rx_sr    <= '0;
        end else if (!en) begin
            active   <= 1'b0;
            edge_cnt <= '0;
            sclk_o   <= cfg.cpol;
        end else if (start || reload) begin
            active   <= 1'b1;
            edge_cnt <= '0;
            sclk_o   <= cfg.cpol;
            rx_sr    <= '0;
            if (!cfg.cpha) begin
                mosi_o <= tx_word[cfg.last_bit];
                tx_sr  <= tx_word << 1;
            end else begin
                tx_sr  <= tx_word;
            end
        end else if (done) begin
            active   <= 1'b0;
            edge_cnt <= '0;
            sclk_o   <= cfg.cpol;
        end else if (active && tick) begin
            sclk_o   <= ~sclk_o;
            edge_cnt <= edge_cnt + 1'b1;
            rx_sr    <= rx_next;
            if (drive_e) begin
                mosi_o <= tx_sr[cfg.last_bit];
                tx_sr  <= tx_sr << 1;
            end
        end else if (!active) begin
            sclk_o <= cfg.cpol;
        end
    end

    assert_idle_level_R12: assert property (@(posedge clk) disable iff (rst)
        !en |=> (sclk_o == $past(cfg.cpol)));

    assert_sclk_paced_R3: assert property (@(posedge clk) disable iff (rst)
        (en && active && !tick) |=> $stable(sclk_o));

endmodule

// File: rtl/ssp_master.sv
module ssp_master #(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    import ssp_pkg::*;

    localparam int CW   = $clog2(FIFO_DEPTH + 1);
    localparam int HALF = FIFO_DEPTH / 2;
    localparam int W    = FRAME_MAX;

    fmt_reg_t  fmt_q;
    port_reg_t port_q;
    logic [7:0] pre_q;
    logic       ovr_q;

    logic sel_fmt, sel_port, sel_data, sel_stat, sel_pre, sel_int;
    assign sel_fmt  = (bus_addr == OFS_CTRL_FMT);
    assign sel_port = (bus_addr == OFS_CTRL_PORT);
    assign sel_data = (bus_addr == OFS_DATA);
    assign sel_stat = (bus_addr == OFS_STATUS);
    assign sel_pre  = (bus_addr == OFS_PRESCALE);
    assign sel_int  = (bus_addr == OFS_INT);

    logic [W-1:0]  tx_head, rx_head, rx_word;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          tx_take, rx_put, rx_pop, link_active, tick;
    link_cfg_t     link_cfg;

    assign rx_pop = bus_rd && sel_data;

    assign link_cfg.cpol     = fmt_q.cpol;
    assign link_cfg.cpha     = fmt_q.cpha;
    assign link_cfg.last_bit = fix_size(fmt_q.size_code);

    ssp_fifo #(.WIDTH(W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(bus_wr && sel_data), .wdata(bus_wdata),
        .pop(tx_take), .rdata(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    ssp_fifo #(.WIDTH(W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(rx_put), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    ssp_clkdiv u_div (
        .clk(clk), .rst(rst), .run(link_active),
        .prescale(pre_q), .rate(fmt_q.rate), .tick(tick)
    );

    ssp_shifter #(.W(W)) u_link (
        .clk(clk), .rst(rst), .en(port_q.en), .loop(port_q.loop),
        .cfg(link_cfg), .tick(tick),
        .tx_valid(!tx_empty), .tx_word(tx_head), .tx_take(tx_take),
        .rx_put(rx_put), .rx_word(rx_word), .active(link_active),
        .sclk_o(spi_sclk), .mosi_o(spi_mosi), .miso_i(spi_miso)
    );

    logic ovr_event;
    assign ovr_event = rx_put && rx_full && !rx_pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q  <= '0;
            port_q <= '0;
            pre_q  <= 8'd2;
            ovr_q  <= 1'b0;
        end else begin
            if (bus_wr && sel_fmt)  fmt_q  <= fmt_reg_t'(bus_wdata);
            if (bus_wr && sel_port) port_q <= port_reg_t'(bus_wdata[4:0]);
            if (bus_wr && sel_pre)  pre_q  <= {bus_wdata[7:1], 1'b0};
            if (ovr_event)                ovr_q <= 1'b1;
            else if (bus_wr && sel_int)   ovr_q <= 1'b0;
        end
    end

    logic [2:0] int_src;
    logic [4:0] status;
    assign int_src[0] = port_q.rx_ie  && (rx_cnt >= CW'(HALF));
    assign int_src[1] = port_q.tx_ie  && (tx_cnt <= CW'(HALF));
    assign int_src[2] = port_q.ovr_ie && ovr_q;
    assign irq        = |int_src;
    assign status     = {link_active || !tx_empty, rx_full, !rx_empty, !tx_full, tx_empty};

    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            sel_fmt:  bus_rdata = fmt_q;
            sel_port: bus_rdata = 16'(port_q);
            sel_data: bus_rdata = rx_empty ? '0 : rx_head;
            sel_stat: bus_rdata = 16'(status);
            sel_pre:  bus_rdata = 16'(pre_q);
            sel_int:  bus_rdata = 16'(int_src);
            default:  bus_rdata = '0;
        endcase
    end

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !(bus_wr && sel_int)) |=> ovr_q);

    assert_rx_read_pops_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && !rx_empty && !rx_put) |=> (rx_cnt == $past(rx_cnt) - 1'b1));

endmodule

// File: tb/tb_ssp_master.sv
module tb_ssp_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;

    always #5 clk = ~clk;

    ssp_master dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // device model state
    int         m_n = 8, m_h = 1, frames = 0;
    bit         m_cpol = 0, m_cpha = 0, m_loop = 0, hold = 1;
    int         exp_tx[$], resp_q[$], exp_rx[$];
    int         e_idx = 0, bp = 0, cyc = 0, got = 0;
    bit         loaded = 0, prev = 0;
    logic [15:0] cur_resp = '0;

    always @(negedge clk) begin
        if (rst || hold) begin
            e_idx = 0; bp = 0; cyc = 0; got = 0; loaded = 0;
            prev = spi_sclk;
        end else begin
            cyc++;
            if (spi_sclk !== prev) begin
                automatic bit lead = (prev == m_cpol);
                automatic int mask = (1 << m_n) - 1;
                if (e_idx > 0) chk(cyc == m_h, "R3 half period", cyc, m_h);
                else           chk(lead, "R4 first edge leaves rest level", spi_sclk, !m_cpol);
                cyc = 0;
                if (m_cpha ? !lead : lead) got = (got << 1) | int'(spi_mosi);
                if (!m_cpha && !lead && e_idx != 2*m_n-1) begin
                    spi_miso = cur_resp[m_n-1-bp]; bp++;
                end
                if (m_cpha && lead) begin
                    spi_miso = cur_resp[m_n-1-bp]; bp++;
                end
                e_idx++;
                if (e_idx == 2*m_n) begin
                    frames++;
                    if (exp_tx.size() == 0) chk(0, "R6 unexpected frame", got, -1);
                    else begin
                        automatic int e = exp_tx.pop_front();
                        chk(got == (e & mask), "R2/R5 mosi frame", got, e & mask);
                        exp_rx.push_back(m_loop ? (e & mask) : (int'(cur_resp) & mask));
                    end
                    e_idx = 0; bp = 0; got = 0; loaded = 0;
                end
            end
            prev = spi_sclk;
            if (!loaded && resp_q.size() > 0) begin
                cur_resp = 16'(resp_q.pop_front());
                loaded = 1; bp = 0;
                if (!m_cpha) begin spi_miso = cur_resp[m_n-1]; bp = 1; end
            end
        end
    end

    int wd = 0;
    always @(negedge clk) begin
        wd++;
        if (wd > 150000) begin
            chk(0, "watchdog", wd, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wr(input logic [4:0] a, input int d);
        @(negedge clk);
        bus_addr = a; bus_wdata = 16'(d); bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = int'(bus_rdata);
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic cfg(input int n, input bit cpol, input bit cpha, input int rate,
                       input int pre, input bit lp);
        automatic int ep = pre & 'hFE;
        hold = 1;
        wr(5'h04, 0);
        wr(5'h10, pre);
        wr(5'h00, (rate << 8) | (int'(cpol) << 7) | (int'(cpha) << 6) | (n - 1));
        if (ep < 2) ep = 2;
        m_n = n; m_cpol = cpol; m_cpha = cpha; m_loop = lp;
        m_h = (ep / 2) * (rate + 1);
        exp_tx.delete(); resp_q.delete(); exp_rx.delete(); frames = 0;
        repeat (3) @(posedge clk);
        #1 hold = 0;
    endtask

    task automatic send(input int w, input int r, input bit taken);
        if (taken) begin exp_tx.push_back(w); resp_q.push_back(r); end
        wr(5'h08, w);
    endtask

    task automatic wait_idle();
        automatic int s;
        do rd(5'h0C, s); while (s[4]);
        repeat (2) @(negedge clk);
        chk(spi_sclk == m_cpol, "R4 rest level", spi_sclk, m_cpol);
        chk(exp_tx.size() == 0, "R5 all frames sent", exp_tx.size(), 0);
    endtask

    task automatic drain(input string req);
        automatic int d;
        while (exp_rx.size() > 0) begin
            automatic int e = exp_rx.pop_front();
            rd(5'h08, d);
            chk(d == e, req, d, e);
        end
    endtask

    initial begin
        automatic int v;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state, R7 empty read
        rd(5'h00, v); chk(v == 0, "R1 format reg", v, 0);
        rd(5'h04, v); chk(v == 0, "R1 port reg", v, 0);
        rd(5'h10, v); chk(v == 2, "R1 prescale", v, 2);
        rd(5'h0C, v); chk(v == 3, "R1 status", v, 3);
        rd(5'h14, v); chk(v == 0, "R1 identify", v, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        chk(spi_sclk == 0, "R1 sclk", spi_sclk, 0);
        rd(5'h08, v); chk(v == 0, "R7 empty read", v, 0);

        // mode 0, 8 bit, fastest clock; upper data bits dropped (R2)
        cfg(8, 0, 0, 0, 2, 0);
        send('hA5, 'h5A, 1); send('h3C, 'hC3, 1); send('hFF0, 'h81, 1);
        wr(5'h04, 'h10);
        wait_idle(); drain("R5 mode0 rx");

        // mode 3, 16 bit, odd prescale acts as 4
        cfg(16, 1, 1, 2, 5, 0);
        send('hBEEF, 'h8001, 1); send('h1234, 'h7FFE, 1);
        wr(5'h04, 'h10);
        wait_idle(); drain("R4 mode3 rx");

        // mode 1, 4 bit
        cfg(4, 0, 1, 1, 6, 0);
        send('h9, 'h6, 1); send('h6, 'hC, 1); send('hA3, 'h1, 1);
        wr(5'h04, 'h10);
        wait_idle(); drain("R2 4-bit rx");

        // mode 2, 5 bit
        cfg(5, 1, 0, 3, 2, 0);
        send('h15, 'h0A, 1); send('h0E, 'h1F, 1);
        wr(5'h04, 'h10);
        wait_idle(); drain("R4 mode2 rx");

        // R11 loopback, R10 receive threshold
        cfg(12, 0, 0, 0, 2, 1);
        send('hABC, 'h543, 1); send('h123, 'hEDC, 1); send('hF0F, 'h0F0, 1); send('h801, 'h7FE, 1);
        wr(5'h04, 'h19);
        wait_idle();
        rd(5'h14, v); chk(v == 1, "R10 rx source", v, 1);
        chk(irq == 1, "R10 irq rx", irq, 1);
        rd(5'h0C, v); chk(v == 7, "R8 status rx pending", v, 7);
        drain("R11 loopback rx");

        // R6 queue full, R10 tx source, R9 overrun
        cfg(8, 0, 0, 0, 2, 0);
        wr(5'h04, 'h02);
        rd(5'h14, v); chk(v == 2, "R10 tx source", v, 2);
        chk(irq == 1, "R10 irq tx", irq, 1);
        for (int i = 0; i < 8; i++) send(i * 17 + 1, 'hF0 - i, 1);
        rd(5'h14, v); chk(v == 0, "R10 tx above half", v, 0);
        rd(5'h0C, v); chk(v == 'h10, "R8 status tx full", v, 'h10);
        send('h77, 'h00, 0);
        wr(5'h04, 'h14);
        wait_idle();
        chk(frames == 8, "R6 dropped write", frames, 8);
        rd(5'h0C, v); chk(v == 'h0F, "R8 status rx full", v, 'h0F);
        rd(5'h14, v); chk(v == 0, "R9 no overrun yet", v, 0);
        send('h99, 'h66, 1);
        wait_idle();
        rd(5'h14, v); chk(v == 4, "R9 overrun flagged", v, 4);
        chk(irq == 1, "R9 irq overrun", irq, 1);
        for (int i = 0; i < 8; i++) begin
            automatic int e = exp_rx.pop_front();
            rd(5'h08, v); chk(v == e, "R7 rx order after overrun", v, e);
        end
        void'(exp_rx.pop_front());
        rd(5'h0C, v); chk(v == 3, "R9 overrun frame dropped", v, 3);
        rd(5'h14, v); chk(v == 4, "R9 flag sticky", v, 4);
        wr(5'h14, 0);
        rd(5'h14, v); chk(v == 0, "R9 cleared", v, 0);
        chk(irq == 0, "R9 irq cleared", irq, 0);

        // R12 disable in the middle of a frame
        cfg(16, 1, 0, 9, 2, 0);
        send('hC3A5, 'h0F0F, 1);
        wr(5'h04, 'h10);
        repeat (60) @(posedge clk);
        #1 hold = 1;
        wr(5'h04, 0);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(spi_sclk == 1, "R12 sclk at rest", spi_sclk, 1);
        end
        rd(5'h0C, v); chk(v == 3, "R12 idle, no partial frame", v, 3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule